// File: doc/BRIEF.md
# Timed Sample Packet Deframer

This block takes transmit packets arriving as 36-bit words over a valid/ready stream and turns them into one wide entry per payload sample for a downstream sample queue. Each word holds a 4-bit framing nibble above 32 data bits. The first word of a packet is a header. It gives a trailer flag, burst start and end flags, a timestamp-present mark, a 4-bit sequence number and the packet length in 32-bit words. When a timestamp is present, three words follow the header: a whole-seconds word, which is discarded, then the high and low halves of a 64-bit tick count. Payload words are single 32-bit samples. An optional trailer word closes the packet.

Every emitted entry carries the sample, its 0-based index in the packet, the 64-bit send time and five flags. The flags mark burst start, burst end, timed send, the last sample of the packet, and a sequence mismatch. The block checks that the framing nibbles agree with the header length. On a framing fault it raises a one-cycle error pulse and discards the rest of the packet. A small settings write port lets software load the expected sequence number.

Top module: `tpkt_deframer`

## Requirements
- R1: The framing nibble is `in_data[35:32]`: 4'b0001 marks a packet's first word and 4'b0010 its last. A word accepted between packets whose nibble is not 4'b0001 is discarded and raises `err_pulse`.
- R2: Header fields are trailer flag bit 26, burst start bit 25, burst end bit 24, timestamp present when bits 23, 22 and 20 are all set, sequence number bits 19:16, and length bits 15:0. The length counts the header, so length = 1 + samples + (trailer ? 1 : 0) + (timestamp ? 3 : 0). A header whose length leaves no room for at least one sample raises `err_pulse`, emits nothing and discards words through the next last-marked word.
- R3: With a timestamp, the entry time field is {second tick word, third tick word} and the send-at flag is 1; the seconds word does not appear in any entry. Without a timestamp, the time field is 0 and send-at is 0.
- R4: Each payload word yields exactly one entry, in arrival order. The layout is sample in bits 31:0, sample index in bits 47:32, time in bits 111:48, and flags in bits 116:112. The flags are burst start (116), burst end (115), send-at (114), last sample (113) and sequence error (112).
- R5: Burst start appears only on the entry with index 0, and only when header bit 25 is set. Burst end appears only on the last sample, and only when header bit 24 is set. The last-sample flag is set on the final sample of every packet.
- R6: When a trailer is present, the trailer word produces no entry and the final sample word carries nibble 4'b0000.
- R7: A last-marked word arriving before the length is used up raises `err_pulse` and produces no entry. Entries already emitted for that packet stay, and the next word is treated as a new packet start.
- R8: If the length is used up on a word that is not last-marked, that word produces no entry, `err_pulse` is raised, and words are discarded without further error through the next last-marked word.
- R9: The expected sequence number resets to 0 and becomes (header sequence + 1) mod 16 after each accepted valid header. Every entry of a packet whose sequence differs from the expected value carries the sequence-error flag.
- R10: A settings write with `cfg_addr` equal to parameter `CFG_BASE` (default 8'h10) loads the expected sequence number from `cfg_data[3:0]`. Writes to any other address have no effect.
- R11: `in_ready` is low only while an entry is held (`out_valid` high) and `out_ready` is low. A held entry stays unchanged until taken, so no entry is lost or duplicated under backpressure.
- R12: `err_pulse` is high for exactly one cycle, the cycle after the offending word is accepted.
- R13: After reset, `out_valid` and `err_pulse` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_stb | input | 1 | Settings write strobe |
| cfg_addr | input | 8 | Settings write address |
| cfg_data | input | 32 | Settings write data |
| in_data | input | 36 | Framing nibble and 32-bit packet word |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with valid |
| out_data | output | 117 | Sample entry: flags, time, index, sample |
| out_valid | output | 1 | Entry valid |
| out_ready | input | 1 | Downstream queue can take the entry |
| err_pulse | output | 1 | One-cycle framing error indication |

## Verification
Plain packets, timed packets with trailers, and single-sample bursts tell apart the three header layouts. They show whether index, time and flags land in the right fields. Sequence jumps and settings writes to the right and wrong addresses separate a resync from a stuck counter. Early and late end marks, short lengths and stray words between packets each leave a distinct count of entries and error pulses. A stalling downstream queue shows whether entries are lost or duplicated.

// File: rtl/tpkt_pkg.sv
// Shared constants and types for the timed sample packet deframer.
// Assumes a single 32-bit sample channel per payload word.
package tpkt_pkg;
    localparam logic [3:0] NIB_FIRST = 4'b0001;
    localparam logic [3:0] NIB_LAST  = 4'b0010;

    // Flag positions inside the 5-bit flag field of an entry
    localparam int F_SERR   = 0;
    localparam int F_LAST   = 1;
    localparam int F_SENDAT = 2;
    localparam int F_EOB    = 3;
    localparam int F_SOB    = 4;

    typedef enum logic [2:0] {
        ST_IDLE, ST_TS_SEC, ST_TS_HI, ST_TS_LO, ST_SAMP, ST_TRAIL, ST_DROP
    } fsm_t;
endpackage

// File: rtl/tpkt_hdr_decode.sv
// Header decoder: turns the header fields into a word count that follows
// the header and flags a length too short to hold one sample.
// Assumes the length field counts the header word itself.
module tpkt_hdr_decode #(
    parameter int LEN_W = 16
) (
    input  logic             trl_bit,
    input  logic [2:0]       ts_marks,
    input  logic [LEN_W-1:0] len,
    output logic             timed,
    output logic [LEN_W-1:0] rem_init,
    output logic             len_bad
);
    logic [LEN_W-1:0] overhead;

    // Decode timestamp presence, overhead words and remaining word count
    always_comb begin
        timed    = &ts_marks;
        overhead = LEN_W'(1) + (timed ? LEN_W'(3) : '0) + LEN_W'(trl_bit);
        rem_init = len - LEN_W'(1);
        len_bad  = (len <= overhead);
    end
endmodule

// File: rtl/tpkt_seq_track.sv
// Sequence tracker: holds the expected packet sequence number, resyncs to
// received+1 on every valid header, and is loadable through a settings write.
// Assumes a settings write and a header in the same cycle favour the write.
module tpkt_seq_track #(
    parameter int          SEQ_W    = 4,
    parameter int          CFG_AW   = 8,
    parameter int          CFG_DW   = 32,
    parameter logic [7:0]  CFG_BASE = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_stb,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_data,
    input  logic              hdr_take,
    input  logic [SEQ_W-1:0]  hdr_seq,
    output logic              mismatch
);
    logic [SEQ_W-1:0] exp_q;
    logic             cfg_hit;
    logic             unused_cfg_hi;

    assign unused_cfg_hi = ^cfg_data[CFG_DW-1:SEQ_W];
    assign cfg_hit       = cfg_stb && (cfg_addr == CFG_AW'(CFG_BASE));
    assign mismatch      = (hdr_seq != exp_q);

    // Update the expected sequence number
    always_ff @(posedge clk) begin
        if (!rst_n)        exp_q <= '0;
        else if (cfg_hit)  exp_q <= cfg_data[SEQ_W-1:0];
        else if (hdr_take) exp_q <= hdr_seq + SEQ_W'(1);
    end

    // R10: a write to the base address loads the expected value
    a_r10_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_hit |=> exp_q == $past(cfg_data[SEQ_W-1:0]));
    // R9: after a header (no write) the next expected is header seq + 1
    a_r9_resync: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_take && !cfg_hit) |=> exp_q == $past(hdr_seq) + SEQ_W'(1));
endmodule

// File: rtl/tpkt_deframer.sv
// Timed sample packet deframer top: parses header and optional timestamp,
// strips header, timestamp and trailer, checks framing against the length,
// and emits one entry per sample through a single output register.
// Assumes one 32-bit sample per payload word and packets of >= 1 sample.
module tpkt_deframer
    import tpkt_pkg::*;
#(
    parameter int         DATA_W   = 32,
    parameter int         NIB_W    = 4,
    parameter int         TIME_W   = 64,
    parameter int         IDX_W    = 16,
    parameter int         LEN_W    = 16,
    parameter int         SEQ_W    = 4,
    parameter int         FLAG_W   = 5,
    parameter int         CFG_AW   = 8,
    parameter int         CFG_DW   = 32,
    parameter logic [7:0] CFG_BASE = 8'h10,
    localparam int        IN_W     = NIB_W + DATA_W,
    localparam int        IDX_LO   = DATA_W,
    localparam int        TIME_LO  = DATA_W + IDX_W,
    localparam int        FLAG_LO  = TIME_LO + TIME_W,
    localparam int        OUT_W    = FLAG_LO + FLAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_stb,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_data,
    input  logic [IN_W-1:0]   in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [OUT_W-1:0]  out_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              err_pulse
);
    localparam int HALF_T = TIME_W / 2;

    fsm_t              st_q, st_nx;
    logic [LEN_W-1:0]  rem_q;
    logic [IDX_W-1:0]  idx_q;
    logic [TIME_W-1:0] time_q;
    logic              sob_q, eob_q, timed_q, trl_q, serr_q;
    logic              err_q;

    logic              acc, is_first, is_last, last_samp;
    logic              emit, err_now, hdr_take;
    logic              hdr_timed, hdr_bad, seq_mis;
    logic [LEN_W-1:0]  hdr_rem;
    logic [NIB_W-1:0]  nib;
    logic [DATA_W-1:0] word;
    logic [FLAG_W-1:0] flags;

    assign nib       = in_data[IN_W-1:DATA_W];
    assign word      = in_data[DATA_W-1:0];
    assign in_ready  = !(out_valid && !out_ready);
    assign acc       = in_valid && in_ready;
    assign is_first  = (nib == NIB_FIRST);
    assign is_last   = (nib == NIB_LAST);
    assign last_samp = trl_q ? (rem_q == LEN_W'(2)) : (rem_q == LEN_W'(1));
    assign err_pulse = err_q;

    tpkt_hdr_decode #(.LEN_W(LEN_W)) u_hdr (
        .trl_bit  (word[26]),
        .ts_marks ({word[23], word[22], word[20]}),
        .len      (word[LEN_W-1:0]),
        .timed    (hdr_timed),
        .rem_init (hdr_rem),
        .len_bad  (hdr_bad)
    );

    tpkt_seq_track #(.SEQ_W(SEQ_W), .CFG_AW(CFG_AW), .CFG_DW(CFG_DW),
                     .CFG_BASE(CFG_BASE)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_stb  (cfg_stb),
        .cfg_addr (cfg_addr),
        .cfg_data (cfg_data),
        .hdr_take (hdr_take),
        .hdr_seq  (word[16 +: SEQ_W]),
        .mismatch (seq_mis)
    );

    // Decide next state, whether the accepted word emits, and framing faults
    always_comb begin
        st_nx    = st_q;
        emit     = 1'b0;
        err_now  = 1'b0;
        hdr_take = 1'b0;
        if (acc) begin
            case (st_q)
                ST_IDLE: begin
                    if (!is_first)     err_now = 1'b1;
                    else if (hdr_bad) begin
                        err_now = 1'b1;
                        st_nx   = ST_DROP;
                    end else begin
                        hdr_take = 1'b1;
                        st_nx    = hdr_timed ? ST_TS_SEC : ST_SAMP;
                    end
                end
                ST_TS_SEC, ST_TS_HI, ST_TS_LO: begin
                    if (is_last) begin
                        err_now = 1'b1;
                        st_nx   = ST_IDLE;
                    end else if (st_q == ST_TS_SEC) st_nx = ST_TS_HI;
                    else if (st_q == ST_TS_HI)      st_nx = ST_TS_LO;
                    else                            st_nx = ST_SAMP;
                end
                ST_SAMP: begin
                    if (is_last && !(last_samp && !trl_q)) begin
                        err_now = 1'b1;
                        st_nx   = ST_IDLE;
                    end else if (last_samp && !trl_q && !is_last) begin
                        err_now = 1'b1;
                        st_nx   = ST_DROP;
                    end else begin
                        emit = 1'b1;
                        if (last_samp) st_nx = trl_q ? ST_TRAIL : ST_IDLE;
                    end
                end
                ST_TRAIL: begin
                    if (!is_last) begin
                        err_now = 1'b1;
                        st_nx   = ST_DROP;
                    end else st_nx = ST_IDLE;
                end
                ST_DROP:  if (is_last) st_nx = ST_IDLE;
                default:  st_nx = ST_IDLE;
            endcase
        end
    end

    // Assemble the flag field of the entry for the current sample
    always_comb begin
        flags           = '0;
        flags[F_SOB]    = sob_q && (idx_q == '0);
        flags[F_EOB]    = eob_q && last_samp;
        flags[F_SENDAT] = timed_q;
        flags[F_LAST]   = last_samp;
        flags[F_SERR]   = serr_q;
    end

    // Parser state, word countdown, sample index and latched header fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            rem_q   <= '0;
            idx_q   <= '0;
            time_q  <= '0;
            sob_q   <= 1'b0;
            eob_q   <= 1'b0;
            timed_q <= 1'b0;
            trl_q   <= 1'b0;
            serr_q  <= 1'b0;
        end else begin
            st_q <= st_nx;
            if (hdr_take) begin
                rem_q   <= hdr_rem;
                idx_q   <= '0;
                time_q  <= '0;
                sob_q   <= word[25];
                eob_q   <= word[24];
                timed_q <= hdr_timed;
                trl_q   <= word[26];
                serr_q  <= seq_mis;
            end else if (acc && st_q != ST_IDLE && st_q != ST_DROP) begin
                rem_q <= rem_q - LEN_W'(1);
                if (st_q == ST_TS_HI) time_q[TIME_W-1:HALF_T] <= word[HALF_T-1:0];
                if (st_q == ST_TS_LO) time_q[HALF_T-1:0]      <= word[HALF_T-1:0];
                if (emit)             idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

    // Output entry register with backpressure hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (emit) begin
            out_valid <= 1'b1;
            out_data  <= {flags, time_q, idx_q, word};
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // Registered one-cycle framing error
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_now;
    end

    // R11: a held entry stays valid and unchanged while not taken
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    // R12: an error pulse only follows an accepted word
    a_r12_err_after_word: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> $past(in_valid && in_ready));
    // R5: burst end only on a last sample, burst start only at index 0
    a_r5_eob_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_data[FLAG_LO+F_EOB]) |-> out_data[FLAG_LO+F_LAST]);
    a_r5_sob_first: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_data[FLAG_LO+F_SOB]) |-> (out_data[IDX_LO +: IDX_W] == '0));
    // R3: untimed entries carry zero time
    a_r3_time_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_data[FLAG_LO+F_SENDAT]) |-> (out_data[TIME_LO +: TIME_W] == '0));
endmodule

// File: tb/tpkt_deframer_bench.sv
module tpkt_deframer_bench;
    localparam logic [7:0] BASE = 8'h10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_stb = 1'b0;
    logic [7:0]   cfg_addr = '0;
    logic [31:0]  cfg_data = '0;
    logic [35:0]  in_data = '0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [116:0] out_data;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic         err_pulse;

    int tests = 0, fails = 0, errs = 0, stalls = 0, bad_ready = 0, cyc = 0;
    bit bp_mode = 0, done = 0;
    logic [116:0] cap[$];
    logic [116:0] expq[$];

    always #10 clk = ~clk;

    tpkt_deframer u_tpkt_deframer (
        .clk(clk), .rst_n(rst_n), .cfg_stb(cfg_stb), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
        .out_ready(out_ready), .err_pulse(err_pulse));

    // downstream ready pattern
    always @(negedge clk) begin
        cyc++;
        out_ready = bp_mode ? (cyc % 3 == 0) : 1'b1;
    end

    // monitor: sample between edges
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            if (out_valid && out_ready) cap.push_back(out_data);
            if (err_pulse) errs++;
            if (out_valid && !out_ready) begin
                stalls++;
                if (in_ready) bad_ready++;
            end else if (!in_ready) bad_ready++;
        end
    end

    function automatic logic [116:0] ent(bit sob, bit eob, bit sa, bit last, bit se,
                                         logic [63:0] t, logic [15:0] idx, logic [31:0] s);
        return {sob, eob, sa, last, se, t, idx, s};
    endfunction

    task automatic chk(string req, logic [127:0] act, logic [127:0] expv);
        tests++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic put(logic [3:0] nib, logic [31:0] d);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = {nib, d};
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic cfg_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        cfg_stb = 1'b1; cfg_addr = a; cfg_data = d;
        @(negedge clk);
        cfg_stb = 1'b0;
    endtask

    // send a well-formed packet and queue the expected entries
    task automatic send_pkt(logic [3:0] seq, bit sob, bit eob, bit ts, logic [63:0] tick,
                            bit tr, int ns, logic [15:0] tag, bit se);
        logic [15:0] len;
        len = 16'(1 + ns + (tr ? 1 : 0) + (ts ? 3 : 0));
        put(4'b0001, {5'b0, tr, sob, eob, ts, ts, 1'b0, ts, seq, len});
        if (ts) begin
            put(4'b0000, 32'hDEAD_0007);
            put(4'b0000, tick[63:32]);
            put(4'b0000, tick[31:0]);
        end
        for (int i = 0; i < ns; i++) begin
            bit lst;
            lst = (i == ns - 1);
            put((lst && !tr) ? 4'b0010 : 4'b0000, {tag, 16'(i)});
            expq.push_back(ent(sob && i == 0, eob && lst, ts, lst, se,
                               ts ? tick : 64'h0, 16'(i), {tag, 16'(i)}));
        end
        if (tr) put(4'b0010, 32'h7A11_E800);
    endtask

    task automatic check_out(string req, int exp_errs);
        repeat (10) @(negedge clk);
        #3;
        chk({req, " entry count"}, 128'(cap.size()), 128'(expq.size()));
        if (cap.size() == expq.size())
            foreach (cap[i]) chk({req, " entry"}, 128'(cap[i]), 128'(expq[i]));
        chk({req, " error pulses"}, 128'(errs), 128'(exp_errs));
        cap.delete(); expq.delete(); errs = 0;
    endtask

    task automatic t_reset();
        chk("R13 in_ready", 128'(in_ready), 128'(1));
        chk("R13 out_valid", 128'(out_valid), 128'(0));
        chk("R13 err_pulse", 128'(err_pulse), 128'(0));
    endtask

    task automatic t_plain();   // R4 R5: untimed, 4 samples, burst start
        send_pkt(4'd0, 1, 0, 0, 64'h0, 0, 4, 16'hA100, 0);
        check_out("R4 R5 plain", 0);
    endtask

    task automatic t_timed();   // R3 R6: timestamp and trailer, burst end
        send_pkt(4'd1, 0, 1, 1, 64'h0000_0001_2345_6789, 1, 3, 16'hB200, 0);
        check_out("R3 R6 timed", 0);
    endtask

    task automatic t_single();  // R5: one sample both start and end
        send_pkt(4'd2, 1, 1, 0, 64'h0, 0, 1, 16'hC300, 0);
        check_out("R5 single", 0);
    endtask

    task automatic t_seq();     // R9: jump flags, next in order does not
        send_pkt(4'd7, 0, 0, 0, 64'h0, 0, 2, 16'hD400, 1);
        send_pkt(4'd8, 0, 0, 0, 64'h0, 1, 2, 16'hD500, 0);
        check_out("R9 sequence", 0);
    endtask

    task automatic t_cfg();     // R10: only the base address loads
        cfg_write(BASE + 8'd1, 32'h0);
        send_pkt(4'd9, 0, 0, 0, 64'h0, 0, 1, 16'hE600, 0);
        cfg_write(BASE, 32'hFFFF_FFF5);
        send_pkt(4'd5, 0, 0, 0, 64'h0, 0, 1, 16'hE700, 0);
        check_out("R10 settings", 0);
    endtask

    task automatic t_early();   // R7 R12: end mark on second of four samples
        put(4'b0001, {5'b0, 3'b010, 4'b0000, 4'd6, 16'd5});
        put(4'b0000, 32'h1111_0000);
        put(4'b0010, 32'h1111_0001);
        expq.push_back(ent(1, 0, 0, 0, 0, 64'h0, 16'd0, 32'h1111_0000));
        send_pkt(4'd7, 0, 0, 0, 64'h0, 0, 1, 16'h1200, 0);
        check_out("R7 R12 early end", 1);
    endtask

    task automatic t_late();    // R8: count runs out without end mark
        put(4'b0001, {5'b0, 3'b000, 4'b0000, 4'd8, 16'd2});
        put(4'b0000, 32'h2222_0000);
        put(4'b0000, 32'h2222_0001);
        put(4'b0010, 32'h2222_0002);
        send_pkt(4'd9, 0, 0, 0, 64'h0, 0, 1, 16'h2300, 0);
        check_out("R8 missing end", 1);
    endtask

    task automatic t_badlen();  // R2: timed header too short, seq not taken
        put(4'b0001, {5'b0, 3'b000, 4'b1101, 4'd10, 16'd4});
        put(4'b0000, 32'h3333_0000);
        put(4'b0000, 32'h3333_0001);
        put(4'b0010, 32'h3333_0002);
        send_pkt(4'd10, 0, 0, 0, 64'h0, 0, 1, 16'h3400, 0);
        check_out("R2 short length", 1);
    endtask

    task automatic t_stray();   // R1: non-first word between packets
        put(4'b0000, 32'h4444_4444);
        send_pkt(4'd11, 0, 0, 0, 64'h0, 0, 1, 16'h4500, 0);
        check_out("R1 stray word", 1);
    endtask

    task automatic t_bp();      // R11: stalling downstream
        bp_mode = 1; stalls = 0; bad_ready = 0;
        send_pkt(4'd12, 1, 0, 1, 64'hFEDC_BA98_7654_3210, 0, 6, 16'h5600, 0);
        send_pkt(4'd13, 0, 1, 0, 64'h0, 1, 2, 16'h5700, 0);
        repeat (12) @(negedge clk);
        bp_mode = 0;
        check_out("R11 backpressure", 0);
        chk("R11 stalls seen", 128'(stalls > 0), 128'(1));
        chk("R11 ready rule", 128'(bad_ready), 128'(0));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #3;
        t_reset();
        t_plain();
        t_timed();
        t_single();
        t_seq();
        t_cfg();
        t_early();
        t_late();
        t_badlen();
        t_stray();
        t_bp();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule